// File: doc/BRIEF.md
# Dual-Processor Word Mailbox with Doorbell

This block joins two processors that share one clock. Each processor sees four 32-bit registers on its own single-cycle bus: a handshake register, a control/status register, a transmit port and a receive port. A word written to one side's transmit port enters a 16-entry FIFO. The other side reads that FIFO through its receive port. There are two such FIFOs, one for each direction, so both sides can send at the same time.

Besides the FIFOs, each side publishes a 4-bit value that the other side can read, and it can ring a doorbell on the other side. Each side has one level interrupt output. It combines the doorbell, the "transmit FIFO empty" condition and the "receive FIFO not empty" condition, and each of these sources has its own enable. A read from an empty FIFO, or a write to a full one, sets a sticky error flag. Software clears the flag by writing 1 to it. Software normally sends a message as an ID word, a header word and payload words, at most 64 words in total.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, the control register of each side reads 0x0000_0101 (both FIFOs empty, everything disabled), and the handshake register reads 0.
- R2: Bits 11:8 of the handshake register are read/write. The other side reads their value in bits 3:0 of its own handshake register. A write to bits 3:0 is ignored.
- R3: Words written at offset 0x8 on one side are read at offset 0xC on the other side in the same order. Each FIFO holds 16 words.
- R4: Control bits 0 and 1 show this side's transmit FIFO empty and full. Bits 8 and 9 show its receive FIFO empty and full.
- R5: A write to a full transmit FIFO, or a read of an empty receive FIFO, sets control bit 14 and changes no FIFO. Writing 1 to bit 14 clears it. Writing 0 leaves it as it is.
- R6: A read of an empty receive FIFO returns the word most recently popped on that side.
- R7: Writing 1 to control bit 3 empties this side's transmit FIFO. Bit 3 always reads 0.
- R8: While control bit 15 (enable) is 0, writes to the transmit port and reads of the receive port are ignored and set no error.
- R9: Writing handshake bit 13 as 1 raises the other side's interrupt for exactly one cycle, in the cycle after the write. This happens only if the other side has set its handshake bit 14.
- R10: The interrupt is high while control bit 2 is set and the transmit FIFO is empty. It is also high while control bit 10 is set and the receive FIFO is not empty.
- R11: The two directions are independent. Words sent from the second side to the first arrive in order and do not disturb the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | 4 | Side A byte offset (0x0 handshake, 0x4 control, 0x8 transmit, 0xC receive) |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe (a read at 0xC pops the receive FIFO) |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from the addressed register |
| a_irq | output | 1 | Side A interrupt level |
| b_addr | input | 4 | Side B byte offset |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt level |

## Verification
The main traffic is a 64-word message that goes from A to B in four bursts. Each burst fills the FIFO to exactly 16 words and then drains it, so any loss, duplication or reordering is caught at the wrap of the pointers. Writes to a full FIFO and reads of an empty one show whether an overflow or underflow is correctly refused and flagged, and whether the stale-read value is correct. Shorter bursts from B to A, a flush in the middle of a burst, and traffic sent while the enable is off show whether the channels are independent and whether gating is correct. The doorbell is rung with the remote enable both on and off, which shows whether it lasts one cycle and whether it is masked.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    REG_HS   = 2'd0,
    REG_CTL  = 2'd1,
    REG_TX   = 2'd2,
    REG_RX   = 2'd3
  } reg_sel_e;

  localparam int HS_NIB_LO   = 8;
  localparam int HS_RING     = 13;
  localparam int HS_IE       = 14;
  localparam int CTL_TX_EMP  = 0;
  localparam int CTL_TX_FUL  = 1;
  localparam int CTL_TX_IE   = 2;
  localparam int CTL_FLUSH   = 3;
  localparam int CTL_RX_EMP  = 8;
  localparam int CTL_RX_FUL  = 9;
  localparam int CTL_RX_IE   = 10;
  localparam int CTL_ERR     = 14;
  localparam int CTL_EN      = 15;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign head    = mem[rp_q];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      rp_d  = wp_q;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = bump(wp_q);
      if (do_pop)  rp_d = bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   addr,
  input  logic         wr,
  input  logic         rd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq,
  input  logic [3:0]   rmt_nib,
  input  logic         ring_in,
  output logic [3:0]   nib_out,
  output logic         ring_out,
  input  logic         tx_empty,
  input  logic         tx_full,
  input  logic         rx_empty,
  input  logic         rx_full,
  input  logic [W-1:0] rx_head,
  output logic         push,
  output logic         pop,
  output logic         flush
);
  reg_sel_e     sel;
  logic         wr_hs, wr_ctl, wr_tx, rd_rx, err_set;
  logic [3:0]   nib_q, nib_d;
  logic         ie_q, ie_d, ring_q, ring_d;
  logic         en_q, en_d, txie_q, txie_d, rxie_q, rxie_d, err_q, err_d;
  logic [W-1:0] last_q, last_d;
  logic         last_en;

  assign sel     = reg_sel_e'(addr[3:2]);
  assign wr_hs   = wr && (sel == REG_HS);
  assign wr_ctl  = wr && (sel == REG_CTL);
  assign wr_tx   = wr && (sel == REG_TX);
  assign rd_rx   = rd && (sel == REG_RX);
  assign push    = wr_tx && en_q && !tx_full;
  assign pop     = rd_rx && en_q && !rx_empty;
  assign flush   = wr_ctl && wdata[CTL_FLUSH];
  assign err_set = en_q && ((wr_tx && tx_full) || (rd_rx && rx_empty));
  assign last_en = pop;

  always_comb begin
    nib_d  = wr_hs  ? wdata[HS_NIB_LO +: 4] : nib_q;
    ie_d   = wr_hs  ? wdata[HS_IE]          : ie_q;
    ring_d = wr_hs  && wdata[HS_RING];
    en_d   = wr_ctl ? wdata[CTL_EN]         : en_q;
    txie_d = wr_ctl ? wdata[CTL_TX_IE]      : txie_q;
    rxie_d = wr_ctl ? wdata[CTL_RX_IE]      : rxie_q;
    err_d  = err_set || (err_q && !(wr_ctl && wdata[CTL_ERR]));
    last_d = rx_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q  <= '0;
      ie_q   <= 1'b0;
      ring_q <= 1'b0;
      en_q   <= 1'b0;
      txie_q <= 1'b0;
      rxie_q <= 1'b0;
      err_q  <= 1'b0;
      last_q <= '0;
    end else begin
      nib_q  <= nib_d;
      ie_q   <= ie_d;
      ring_q <= ring_d;
      en_q   <= en_d;
      txie_q <= txie_d;
      rxie_q <= rxie_d;
      err_q  <= err_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign nib_out  = nib_q;
  assign ring_out = ring_q;
  assign irq = (ring_in && ie_q) || (txie_q && tx_empty) || (rxie_q && !rx_empty);

  always_comb begin
    rdata = '0;
    case (sel)
      REG_HS: begin
        rdata[3:0]             = rmt_nib;
        rdata[HS_NIB_LO +: 4]  = nib_q;
        rdata[HS_IE]           = ie_q;
      end
      REG_CTL: begin
        rdata[CTL_TX_EMP] = tx_empty;
        rdata[CTL_TX_FUL] = tx_full;
        rdata[CTL_TX_IE]  = txie_q;
        rdata[CTL_RX_EMP] = rx_empty;
        rdata[CTL_RX_FUL] = rx_full;
        rdata[CTL_RX_IE]  = rxie_q;
        rdata[CTL_ERR]    = err_q;
        rdata[CTL_EN]     = en_q;
      end
      REG_RX:  rdata = (en_q && !rx_empty) ? rx_head : last_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   a_addr,
  input  logic         a_wr,
  input  logic         a_rd,
  input  logic [W-1:0] a_wdata,
  output logic [W-1:0] a_rdata,
  output logic         a_irq,
  input  logic [3:0]   b_addr,
  input  logic         b_wr,
  input  logic         b_rd,
  input  logic [W-1:0] b_wdata,
  output logic [W-1:0] b_rdata,
  output logic         b_irq
);
  // index i = sending side; FIFO i carries side i -> side 1-i
  logic [1:0][3:0]   addr_s, nib_s;
  logic [1:0]        wr_s, rd_s, irq_s, ring_s, push_s, pop_s, flush_s;
  logic [1:0][W-1:0] wdata_s, rdata_s, head_s;
  logic [1:0]        empty_s, full_s;
  logic [1:0][CW-1:0] cnt_s;

  assign addr_s  = {b_addr, a_addr};
  assign wr_s    = {b_wr, a_wr};
  assign rd_s    = {b_rd, a_rd};
  assign wdata_s = {b_wdata, a_wdata};
  assign a_rdata = rdata_s[0];
  assign b_rdata = rdata_s[1];
  assign a_irq   = irq_s[0];
  assign b_irq   = irq_s[1];

  for (genvar i = 0; i < 2; i++) begin : g_side
    mbx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push_s[i]), .pop(pop_s[1-i]), .flush(flush_s[i]),
      .din(wdata_s[i]), .head(head_s[i]),
      .empty(empty_s[i]), .full(full_s[i]), .count(cnt_s[i])
    );
    mbx_port #(.W(W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .addr(addr_s[i]), .wr(wr_s[i]), .rd(rd_s[i]), .wdata(wdata_s[i]),
      .rdata(rdata_s[i]), .irq(irq_s[i]),
      .rmt_nib(nib_s[1-i]), .ring_in(ring_s[1-i]),
      .nib_out(nib_s[i]), .ring_out(ring_s[i]),
      .tx_empty(empty_s[i]), .tx_full(full_s[i]),
      .rx_empty(empty_s[1-i]), .rx_full(full_s[1-i]), .rx_head(head_s[1-i]),
      .push(push_s[i]), .pop(pop_s[i]), .flush(flush_s[i])
    );
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       a_addr,
  input logic             a_wr,
  input logic [31:0]      a_wdata,
  input logic [1:0][CW-1:0] cnt,
  input logic [1:0]       empty,
  input logic [1:0]       full,
  input logic [1:0]       flush,
  input logic [1:0]       pop,
  input logic [1:0]       ring
);
  logic a_ring_wr;
  assign a_ring_wr = a_wr && (a_addr[3:2] == 2'd0) && a_wdata[13];

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] <= CW'(DEPTH)) && (cnt[1] <= CW'(DEPTH)));
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty[0] && full[0]) && !(empty[1] && full[1]));
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full[0] && !pop[1] && !flush[0]) |=> full[0]);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush[0] |=> empty[0]);
  a_r9_ring_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    a_ring_wr |=> ring[0]);
  a_r9_ring_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring[0]) |-> $past(a_ring_wr));
endmodule

bind ipc_mailbox mbx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .a_wr(a_wr), .a_wdata(a_wdata),
  .cnt(cnt_s), .empty(empty_s), .full(full_s), .flush(flush_s),
  .pop(pop_s), .ring(ring_s)
);

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  localparam int PERIOD = 10;
  logic clk, rst_n;
  logic [3:0] a_addr, b_addr;
  logic a_wr, a_rd, b_wr, b_rd, a_irq, b_irq;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata, q;
  int n_chk, n_bad;
  logic [31:0] sb[$];

  ipc_mailbox u0 (.*);

  initial begin clk = 0; forever #(PERIOD/2) clk = ~clk; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit s, input logic [3:0] ad, input bit w, input bit r,
                     input logic [31:0] d, output logic [31:0] rq);
    @(negedge clk);
    if (!s) begin a_addr = ad; a_wr = w; a_rd = r; a_wdata = d; end
    else    begin b_addr = ad; b_wr = w; b_rd = r; b_wdata = d; end
    #1 rq = s ? b_rdata : a_rdata;
    @(posedge clk); #1;
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
  endtask

  // driver: push into the design and the scoreboard
  task automatic send_a(input logic [31:0] d);
    acc(0, 4'h8, 1, 0, d, q);
    sb.push_back(d);
  endtask
  // monitor: pop from the design and compare with the scoreboard
  task automatic recv_b(input string req);
    logic [31:0] e;
    acc(1, 4'hC, 0, 1, 0, q);
    e = (sb.size() != 0) ? sb.pop_front() : 32'hDEAD_BEEF;
    chk(req, q, e);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    a_addr = 0; b_addr = 0; a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
    a_wdata = 0; b_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    acc(0, 4'h4, 0, 0, 0, q); chk("R1 ctl A", q, 32'h0000_0101);
    acc(1, 4'h0, 0, 0, 0, q); chk("R1 hs B", q, 32'h0);

    // R8: disabled side ignores traffic
    acc(0, 4'h8, 1, 0, 32'h1234, q);
    acc(1, 4'h4, 0, 0, 0, q); chk("R8 B rx still empty", q, 32'h0000_0101);
    acc(0, 4'h4, 0, 0, 0, q); chk("R8 A no error", q, 32'h0000_0101);

    acc(0, 4'h4, 1, 0, 32'h8000, q);
    acc(1, 4'h4, 1, 0, 32'h8000, q);

    // R2 nibble exchange; low nibble write ignored
    acc(0, 4'h0, 1, 0, 32'h0000_0A05, q);
    acc(0, 4'h0, 0, 0, 0, q); chk("R2 hs A", q, 32'h0000_0A00);
    acc(1, 4'h0, 0, 0, 0, q); chk("R2 hs B sees A", q, 32'h0000_000A);

    // R3/R4/R5: 64-word message in four full bursts
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 16; k++) begin
        logic [31:0] w;
        w = (c == 0 && k == 0) ? 32'h0000_0007 :
            (c == 0 && k == 1) ? 32'h0040_0000 : {c[7:0], k[7:0], 16'hA5C3 ^ k[15:0]};
        send_a(w);
      end
      acc(0, 4'h4, 0, 0, 0, q); chk("R4 A tx full", q, 32'h0000_8102);
      acc(1, 4'h4, 0, 0, 0, q); chk("R4 B rx full", q, 32'h0000_8201);
      if (c == 0) begin
        acc(0, 4'h8, 1, 0, 32'hBAD0_BAD0, q);
        acc(0, 4'h4, 0, 0, 0, q); chk("R5 overflow err", q, 32'h0000_C102);
        acc(0, 4'h4, 1, 0, 32'h8000, q);
        acc(0, 4'h4, 0, 0, 0, q); chk("R5 write 0 keeps err", q, 32'h0000_C102);
        acc(0, 4'h4, 1, 0, 32'hC000, q);
        acc(0, 4'h4, 0, 0, 0, q); chk("R5 err cleared", q, 32'h0000_8102);
      end
      for (int k = 0; k < 16; k++) recv_b("R3 order");
    end
    acc(1, 4'h4, 0, 0, 0, q); chk("R4 B drained", q, 32'h0000_8101);

    // R6: underflow returns last popped word and sets error
    acc(1, 4'hC, 0, 1, 0, q); chk("R6 stale read", q, {8'd3, 8'd15, 16'hA5C3 ^ 16'd15});
    acc(1, 4'h4, 0, 0, 0, q); chk("R5 underflow err", q, 32'h0000_C101);
    acc(1, 4'h4, 1, 0, 32'hC000, q);

    // R11: reverse direction
    for (int k = 0; k < 3; k++) acc(1, 4'h8, 1, 0, 32'h5000 + k, q);
    acc(0, 4'h4, 0, 0, 0, q); chk("R11 A rx not empty", q, 32'h0000_8001);
    for (int k = 0; k < 3; k++) begin
      acc(0, 4'hC, 0, 1, 0, q); chk("R11 B->A order", q, 32'h5000 + k);
    end

    // R7: flush
    for (int k = 0; k < 5; k++) acc(0, 4'h8, 1, 0, k, q);
    acc(0, 4'h4, 1, 0, 32'h8008, q);
    acc(0, 4'h4, 0, 0, 0, q); chk("R7 flushed", q, 32'h0000_8101);
    acc(1, 4'h4, 0, 0, 0, q); chk("R7 B rx empty", q, 32'h0000_8101);

    // R10: interrupt levels
    acc(0, 4'h4, 1, 0, 32'h8004, q);
    chk("R10 tx empty irq", {31'b0, a_irq}, 32'h1);
    acc(1, 4'h4, 1, 0, 32'h8400, q);
    chk("R10 rx idle no irq", {31'b0, b_irq}, 32'h0);
    acc(0, 4'h8, 1, 0, 32'h77, q);
    chk("R10 rx not empty irq", {31'b0, b_irq}, 32'h1);
    chk("R10 tx not empty drops", {31'b0, a_irq}, 32'h0);
    acc(1, 4'hC, 0, 1, 0, q);
    chk("R10 irq after pop", {31'b0, b_irq}, 32'h0);
    acc(0, 4'h4, 1, 0, 32'h8000, q);
    acc(1, 4'h4, 1, 0, 32'h8000, q);

    // R9: doorbell masked, then enabled
    acc(0, 4'h0, 1, 0, 32'h0000_2000, q);
    chk("R9 masked ring", {31'b0, b_irq}, 32'h0);
    acc(1, 4'h0, 1, 0, 32'h0000_4000, q);
    acc(0, 4'h0, 1, 0, 32'h0000_2000, q);
    chk("R9 ring seen", {31'b0, b_irq}, 32'h1);
    @(posedge clk); #1;
    chk("R9 ring one cycle", {31'b0, b_irq}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule